// File: doc/BRIEF.md
# Sine-Tone Sigma-Delta DAC

This block turns a stored sine period into a one-bit pulse-density stream, which an external low-pass filter smooths back into an analog tone. A phase register walks a synchronously read table that holds one full period of 12-bit offset-binary samples. Each sample is fed to a first-order error-feedback loop. The sign of that loop's accumulator sets the output bit, and the output bit comes straight from a flip-flop.

Software-free control is through two plain inputs. `phase_step` sets the tone frequency as a fraction of the update rate. `rate_div` spaces the updates so that the loop can run on every clock or on every Nth clock. The output is free-running, so there is no valid/ready handshake and no back-pressure: the bit is always valid, and `smp_stb` marks the cycles in which it has just taken a new value. A build-time parameter selects between two feedback gains. The balanced gain puts signal zero at an exact half density. The rail gain makes the table's extreme codes reach a solid one or a solid zero.

Top module: `tone_pdm_dac`

## Requirements
- R1: Reset is synchronous and active high. While it is asserted and on the cycle after it, `pdm_o` and `smp_stb` are 0. The phase restarts at 0, so a zero step after reset plays the signal-zero code 2048.
- R2: An update happens once every `rate_div`+1 clocks. `smp_stb` is high for exactly the one cycle following each update. `pdm_o` changes value only in cycles where `smp_stb` is high.
- R3: On each update the phase advances by `phase_step` modulo 1024. A step of 1023 therefore walks the table backwards.
- R4: Table entry k is 2048 + trunc(2047·sin(2πk/1024)), rounded toward zero on both halves. The table holds one full period, positive half first, and its codes lie between 1 and 4095.
- R5: For a constant code s, with x = s − 2048 and loop gain F (2048 balanced, 2047 rail), the number of ones in any 4096 consecutive updates is within one of 4096·(x+F)/(2F). The accumulator stays within ±2F.
- R6: With the balanced gain, over 4096 updates code 4095 gives 4095 ones, code 1 gives exactly one 1, and code 2048 gives exactly 2048 ones with the bit toggling on every update.
- R7: With the rail gain, over 4096 updates code 4095 gives 4096 ones and code 1 gives no ones.
- R8: While a tone plays over whole periods, the ones count over 4096 updates is within two of 4096·F plus the sum of x over the samples played, all divided by 2F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_step | input | 10 | Phase increment applied on each update |
| rate_div | input | 4 | Update spacing minus one, in clocks |
| pdm_o | output | 1 | Registered pulse-density bit |
| smp_stb | output | 1 | High for one cycle after each update |

## Verification
On every cycle the assertions check the update spacing, the phase advance, that the table never emits code 0, that the accumulator stays within ±2F, that the output holds between strobes, and that reset clears the output. Density is a property of thousands of updates, so only the bench scenarios can show it. The bench pins the phase to chosen codes and plays sweeps in both directions, then compares the counted ones with the density law. It also checks the exact rail and zero counts of each gain.

// File: rtl/tone_pdm_pkg.sv
package tone_pdm_pkg;
  // Selects the error-feedback gain of the modulator loop.
  typedef enum logic {
    MAP_BALANCED = 1'b0,  // gain = half scale: zero code lands on exact 50 %
    MAP_RAIL     = 1'b1   // gain = half scale - 1: extreme codes reach solid rails
  } tone_map_e;

  function automatic int fb_gain(tone_map_e m, int sample_w);
    int half;
    half = 1 << (sample_w - 1);
    return (m == MAP_RAIL) ? half - 1 : half;
  endfunction
endpackage

// File: rtl/tone_tick_gen.sv
module tone_tick_gen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] rate_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= rate_div;
    else           cnt_q <= cnt_q - 1'b1;
  end

  // R2: a divider above zero never yields back-to-back updates
  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && rate_div != '0) |=> !tick);
endmodule

// File: rtl/tone_phase_table.sv
module tone_phase_table #(
  parameter int PH_W     = 10,
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic [PH_W-1:0]     phase_step,
  output logic [SAMPLE_W-1:0] sample
);
  localparam int DEPTH = 1 << PH_W;
  localparam int MID   = 1 << (SAMPLE_W - 1);
  localparam int AMP   = MID - 1;

  logic [SAMPLE_W-1:0] rom [DEPTH];
  logic [PH_W-1:0]     phase_q;

  // One full period, truncated toward zero on both halves.
  initial begin
    real ang_r;
    for (int i = 0; i < DEPTH; i++) begin
      ang_r  = 6.283185307179586 * real'(i) / real'(DEPTH);
      rom[i] = SAMPLE_W'(MID + $rtoi(real'(AMP) * $sin(ang_r)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      sample  <= SAMPLE_W'(MID);
    end else if (tick) begin
      phase_q <= phase_q + phase_step;
      sample  <= rom[phase_q];
    end
  end

  // R3: phase moves by the step, modulo the table size, on each update
  assert_phase_step_R3: assert property (@(posedge clk) disable iff (rst)
    tick |=> phase_q == PH_W'($past(phase_q) + $past(phase_step)));

  // R4: code 0 is never emitted by the symmetric table
  assert_code_range_R4: assert property (@(posedge clk) disable iff (rst)
    sample != '0);
endmodule

// File: rtl/tone_sd_core.sv
module tone_sd_core
  import tone_pdm_pkg::*;
#(
  parameter int        SAMPLE_W = 12,
  parameter tone_map_e MAP      = MAP_BALANCED
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                pdm,
  output logic                stb
);
  localparam int ACC_W = SAMPLE_W + 3;
  localparam int MID   = 1 << (SAMPLE_W - 1);
  localparam int FB    = fb_gain(MAP, SAMPLE_W);
  localparam logic signed [ACC_W-1:0] MID_S   = ACC_W'(MID);
  localparam logic signed [ACC_W-1:0] FB_S    = ACC_W'(FB);
  localparam logic signed [ACC_W-1:0] BOUND_S = ACC_W'(2 * FB);

  logic signed [ACC_W-1:0] cen, hi_q, lo_q, acc_q, acc_n;

  // Stage 1: remove the offset and pre-apply both feedback terms.
  assign cen = $signed({{(ACC_W-SAMPLE_W){1'b0}}, sample}) - MID_S;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= -FB_S;
      lo_q <= FB_S;
    end else if (tick) begin
      hi_q <= cen - FB_S;
      lo_q <= cen + FB_S;
    end
  end

  // Stage 2: a single add, term chosen by the current output bit.
  assign acc_n = acc_q + (pdm ? hi_q : lo_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      pdm   <= 1'b0;
      stb   <= 1'b0;
    end else begin
      stb <= tick;
      if (tick) begin
        acc_q <= acc_n;
        pdm   <= ~acc_n[ACC_W-1];
      end
    end
  end

  // R5: the error integrator stays within twice the loop gain
  assert_acc_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_q >= -BOUND_S) && (acc_q <= BOUND_S));

  // R2: the output bit only moves in a strobe cycle
  assert_hold_between_R2: assert property (@(posedge clk) disable iff (rst)
    !stb |-> $stable(pdm));

  // R1: reset forces a quiet output
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!pdm && !stb));
endmodule

// File: rtl/tone_pdm_dac.sv
module tone_pdm_dac
  import tone_pdm_pkg::*;
#(
  parameter int        PH_W     = 10,
  parameter int        SAMPLE_W = 12,
  parameter int        DIV_W    = 4,
  parameter tone_map_e MAP      = MAP_BALANCED
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PH_W-1:0]  phase_step,
  input  logic [DIV_W-1:0] rate_div,
  output logic             pdm_o,
  output logic             smp_stb
);
  logic                tick;
  logic [SAMPLE_W-1:0] sample;

  tone_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .rate_div(rate_div), .tick(tick)
  );

  tone_phase_table #(.PH_W(PH_W), .SAMPLE_W(SAMPLE_W)) u_table (
    .clk(clk), .rst(rst), .tick(tick), .phase_step(phase_step), .sample(sample)
  );

  tone_sd_core #(.SAMPLE_W(SAMPLE_W), .MAP(MAP)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .sample(sample), .pdm(pdm_o), .stb(smp_stb)
  );
endmodule

// File: tb/tone_pdm_dac_bench.sv
`timescale 1ns/1ps
module tone_pdm_dac_bench;
  localparam int FA = 2048;  // balanced gain
  localparam int FB = 2047;  // rail gain
  localparam int NW = 4096;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] phase_step = '0;
  logic [3:0] rate_div = '0;
  logic       pdm_a, stb_a, pdm_b, stb_b;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tone_pdm_dac u_tone_pdm_dac (
    .clk(clk), .rst(rst), .phase_step(phase_step), .rate_div(rate_div),
    .pdm_o(pdm_a), .smp_stb(stb_a)
  );

  tone_pdm_dac #(.MAP(tone_pdm_pkg::MAP_RAIL)) u_tone_pdm_dac_rail (
    .clk(clk), .rst(rst), .phase_step(phase_step), .rate_div(rate_div),
    .pdm_o(pdm_b), .smp_stb(stb_b)
  );

  // {phase index, rate_div, exact ones balanced, exact ones rail}; -1 = use density law
  localparam int NV = 10;
  localparam int VEC [NV][4] = '{
    '{0,   0, 2048, 2048},
    '{256, 0, 4095, 4096},
    '{768, 0, 1,    0},
    '{128, 0, -1,   -1},
    '{384, 0, -1,   -1},
    '{640, 0, -1,   -1},
    '{896, 0, -1,   -1},
    '{64,  0, -1,   -1},
    '{128, 7, -1,   -1},
    '{768, 7, 1,    0}
  };

  function automatic int x_of(int k);
    return $rtoi(2047.0 * $sin(6.283185307179586 * real'(k) / 1024.0));
  endfunction

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_law(input string req, input int ones, input int sum_x,
                           input int f, input int tol);
    int expn;
    expn = (sum_x + NW * f + f) / (2 * f);
    check(iabs(ones * 2 * f - (sum_x + NW * f)) <= tol * 2 * f, req, ones, expn);
  endtask

  task automatic do_reset(input int k);
    @(negedge clk);
    rst = 1'b1; phase_step = '0; rate_div = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0; phase_step = 10'(k);
    @(negedge clk);
    phase_step = '0;
  endtask

  task automatic count_ones(input int rate, output int ones_a, output int ones_b);
    int seen;
    rate_div = 4'(rate);
    seen = 0;
    while (seen < 40) begin @(negedge clk); if (stb_a) seen++; end
    ones_a = 0; ones_b = 0; seen = 0;
    while (seen < NW) begin
      @(negedge clk);
      if (stb_a) begin
        seen++;
        ones_a += int'(pdm_a);
        ones_b += int'(pdm_b);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int oa, ob, tog_a, tog_b, strobes, bad, sx;
    logic pa, pb;

    // R1: quiet outputs while held in reset from time zero
    repeat (3) @(negedge clk);
    check(pdm_a == 1'b0 && stb_a == 1'b0, "R1 reset balanced", {pdm_a, stb_a}, 0);
    check(pdm_b == 1'b0 && stb_b == 1'b0, "R1 reset rail", {pdm_b, stb_b}, 0);

    // Vector table: pin the phase, hold the code, count ones
    for (int i = 0; i < NV; i++) begin
      do_reset(VEC[i][0]);
      count_ones(VEC[i][1], oa, ob);
      sx = NW * x_of(VEC[i][0]);
      if (VEC[i][2] >= 0) check(oa == VEC[i][2], "R6 balanced exact count", oa, VEC[i][2]);
      else                check_law("R4 R5 balanced density", oa, sx, FA, 1);
      if (VEC[i][3] >= 0) check(ob == VEC[i][3], "R7 rail exact count", ob, VEC[i][3]);
      else                check_law("R4 R5 rail density", ob, sx, FB, 1);
    end

    // R1 + R6: after reset the phase is 0, zero code toggles every update
    do_reset(0);
    repeat (40) @(negedge clk);
    pa = pdm_a; pb = pdm_b; tog_a = 0; tog_b = 0;
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      if (pdm_a != pa) tog_a++;
      if (pdm_b != pb) tog_b++;
      pa = pdm_a; pb = pdm_b;
    end
    check(tog_a == 64, "R1 R6 zero alternation balanced", tog_a, 64);
    check(tog_b == 64, "R1 zero alternation rail", tog_b, 64);

    // R2: strobe spacing and hold between strobes at rate_div = 4
    rate_div = 4'd4;
    repeat (20) @(negedge clk);
    pa = pdm_a; strobes = 0; bad = 0;
    for (int c = 0; c < 500; c++) begin
      @(negedge clk);
      if (stb_a) strobes++;
      if (pdm_a != pa && !stb_a) bad++;
      pa = pdm_a;
    end
    check(strobes == 100, "R2 strobe count", strobes, 100);
    check(bad == 0, "R2 change outside strobe", bad, 0);

    // R2: every-cycle updates at rate_div = 0
    rate_div = 4'd0;
    repeat (5) @(negedge clk);
    strobes = 0;
    for (int c = 0; c < 50; c++) begin @(negedge clk); if (stb_a) strobes++; end
    check(strobes == 50, "R2 full-rate strobes", strobes, 50);

    // R3 + R8: forward sweep, step 4 -> 16 periods in the window
    do_reset(0);
    phase_step = 10'd4;
    count_ones(0, oa, ob);
    sx = 0;
    for (int j = 0; j < 256; j++) sx += x_of(4 * j);
    sx = sx * 16;
    check_law("R3 R8 forward sweep balanced", oa, sx, FA, 2);
    check_law("R3 R8 forward sweep rail", ob, sx, FB, 2);

    // R3 + R8: backward sweep through the wrap, step 1023 -> 4 periods
    do_reset(0);
    phase_step = 10'd1023;
    count_ones(0, oa, ob);
    sx = 0;
    for (int j = 0; j < 1024; j++) sx += x_of(j);
    sx = sx * 4;
    check_law("R3 R8 backward sweep balanced", oa, sx, FA, 2);
    check_law("R3 R8 backward sweep rail", ob, sx, FB, 2);

    // R1: reset asserted mid-run silences the outputs
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(pdm_a == 1'b0 && stb_a == 1'b0, "R1 mid-run reset balanced", {pdm_a, stb_a}, 0);
    check(pdm_b == 1'b0 && stb_b == 1'b0, "R1 mid-run reset rail", {pdm_b, stb_b}, 0);
    rst = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule